// File: doc/BRIEF.md
# SPI Serial Flash Command Front End

This block is the slave-side protocol engine of a byte-wide serial flash model holding 2^19 bytes. It watches chip select, serial clock, the pause pin and serial input from the host. All four are brought into a faster system clock and their edges are found there. The first byte of each selection is taken as a command. The block then collects a 24-bit address when the command needs one. It answers reads, fast reads, status reads and identification reads on the serial output. It hands program data and one-cycle command strobes to the program, erase and status-write units that sit beside it.

The array is reached through a synchronous byte read port: the front end raises `arr_rd_en` with an address, and the byte is expected on `arr_rd_data` on the next system clock. Program data leaves as a stream of address/data beats on `prog_valid`. This stream has no back-pressure, because the host clock cannot be stalled, so the sink must accept every beat it sees. The status byte comes from the status unit on `status_in`. The busy flag comes from whichever unit is running an internal write.

The host clock must be slow enough that each half period spans at least four system clocks.

Top module: `sfe_cmd_frontend`

## Requirements
- R1: After reset and whenever chip select is high, `spi_so_oe` is low and no command strobe, program beat or array read is issued.
- R2: Both idle clock levels work (low, mode 0; high, mode 3). SI is taken on each rising SCK edge and SO changes only after a falling edge. Every byte travels most significant bit first.
- R3: Opcode 05h returns the `status_in` byte, captured at the start of each output byte, repeated for as long as the device stays selected.
- R4: Opcode 03h takes three address bytes. Address bits 23..19 are ignored. It then streams bytes from consecutive array addresses, with SO disabled during the opcode and address.
- R5: A read stream continues from address 00000h right after address 7FFFFh.
- R6: Opcode 0Bh behaves like 03h, except that one extra byte after the address is ignored and SO stays disabled during it.
- R7: Opcodes 9Fh and ABh both stream the bytes 1Fh, 66h, 04h in that order, repeated while selected.
- R8: After any other opcode value, SO stays disabled and all input is ignored until the next selection.
- R9: While `wr_busy` is high when the opcode byte completes, every opcode other than 05h is treated as an unknown opcode.
- R10: Pulling `spi_hold_n` low while SCK is low pauses the transfer and disables SO. Raising it while SCK is low resumes with no bit lost. SCK and SI activity during the pause has no effect.
- R11: On deselection, `cmd_valid` pulses for one cycle with `cmd_op` set to a code, provided the selection carried exactly the right number of bits. The codes are: 06h gives 1 (8 bits). 04h gives 2 (8 bits). 60h or C7h gives 7 (8 bits). 01h gives 3, with `cmd_data` holding the second byte (16 bits). 20h or D7h gives 5, and 52h or D8h gives 6, each with the 19-bit address on `cmd_addr` (32 bits).
- R12: Opcode 02h emits one `prog_valid` beat per whole data byte. The beat address starts at the given address, and its low 8 bits wrap within the 256-byte page. On deselection after at least one whole byte and no partial byte, `cmd_op` 4 pulses with `cmd_addr` set to the page base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_hold_n | input | 1 | Active-low transfer pause |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Drive enable for spi_so (low means high impedance) |
| wr_busy | input | 1 | Internal write or erase in progress |
| status_in | input | 8 | Current status byte |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_addr | output | 19 | Array read address |
| arr_rd_data | input | 8 | Array byte, valid one cycle after the request |
| prog_valid | output | 1 | Program beat valid (no back-pressure) |
| prog_addr | output | 19 | Program beat byte address |
| prog_data | output | 8 | Program beat data |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code, see R11 and R12 |
| cmd_addr | output | 19 | Command address |
| cmd_data | output | 8 | Status-write data byte |

## Verification
The hardest case to reach is a pause that lands in the middle of an output byte. It has to come while SCK is low, with SCK and SI still toggling, and the stream must then carry on bit for bit. The bench splits a read byte after three bits. It drops SCK, lowers the pause pin, clocks garbage and then releases. It checks that SO stays disabled throughout and that the byte and the next one still match the model. The busy lockout and the strobes cancelled by stray bits are reached the same way. The bench drives deliberately misaligned frames and checks that its expected-strobe queue never sees an unplanned entry.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDI  = 3'd2,
    OP_WRSR  = 3'd3,
    OP_PROG  = 3'd4,
    OP_SECT  = 3'd5,
    OP_BLOCK = 3'd6,
    OP_CHIP  = 3'd7
  } sfe_op_e;

  typedef enum logic [3:0] {
    C_WREN, C_WRDI, C_RDSR, C_WRSR, C_READ, C_FAST,
    C_PROG, C_SECT, C_BLOCK, C_CHIP, C_ID, C_BAD
  } sfe_cmd_e;

  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_DUMMY, ST_DATA, ST_TX, ST_ARMED, ST_DEAD
  } sfe_st_e;

  function automatic sfe_cmd_e sfe_decode(input logic [7:0] b);
    case (b)
      8'h06:        return C_WREN;
      8'h04:        return C_WRDI;
      8'h05:        return C_RDSR;
      8'h01:        return C_WRSR;
      8'h03:        return C_READ;
      8'h0B:        return C_FAST;
      8'h02:        return C_PROG;
      8'h20, 8'hD7: return C_SECT;
      8'h52, 8'hD8: return C_BLOCK;
      8'h60, 8'hC7: return C_CHIP;
      8'h9F, 8'hAB: return C_ID;
      default:      return C_BAD;
    endcase
  endfunction

  function automatic sfe_op_e sfe_op_of(input sfe_cmd_e c);
    case (c)
      C_WREN:  return OP_WREN;
      C_WRDI:  return OP_WRDI;
      C_WRSR:  return OP_WRSR;
      C_PROG:  return OP_PROG;
      C_SECT:  return OP_SECT;
      C_BLOCK: return OP_BLOCK;
      C_CHIP:  return OP_CHIP;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_link.sv
module sfe_link (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic sel,
  output logic rise,
  output logic fall,
  output logic desel,
  output logic paused
);
  logic sck_q, cs_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      paused <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_n_q <= cs_n_s;
      // pause state only changes while the serial clock is low
      if (cs_n_s)      paused <= 1'b0;
      else if (!sck_s) paused <= !hold_n_s;
    end
  end

  assign sel   = !cs_n_s;
  assign rise  = sel && !paused && sck_s && !sck_q;
  assign fall  = sel && !paused && !sck_s && sck_q;
  assign desel = cs_n_s && !cs_n_q;
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         so
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clr)   sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign so = sr[W-1];
endmodule

// File: rtl/sfe_cmd_frontend.sv
module sfe_cmd_frontend
  import sfe_pkg::*;
#(
  parameter int         ADDR_W      = 19,
  parameter int         PAGE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_MFR      = 8'h1F,
  parameter logic [7:0] ID_TYPE     = 8'h66,
  parameter logic [7:0] ID_CAP      = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              wr_busy,
  input  logic [7:0]        status_in,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [7:0]        arr_rd_data,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  localparam int ADDR_BYTES = 3;
  localparam int ABYTE_W    = $clog2(ADDR_BYTES);

  logic [3:0] raw_pins, syn_pins;
  logic       sck_s, cs_n_s, hold_n_s, si_s;
  logic       sel, rise, fall, desel, paused;

  assign raw_pins = {spi_sck, spi_cs_n, spi_hold_n, spi_si};

  sfe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(syn_pins)
  );

  assign {sck_s, cs_n_s, hold_n_s, si_s} = syn_pins;

  sfe_link u_link (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .hold_n_s(hold_n_s),
    .sel(sel), .rise(rise), .fall(fall), .desel(desel), .paused(paused)
  );

  sfe_st_e           st;
  sfe_cmd_e          cmd;
  logic [7:0]        rx_sr;
  logic [2:0]        bit_idx;
  logic [ABYTE_W-1:0] abyte;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_data;
  logic              prog_any;
  logic              fetch_q, fetch_d;
  logic [7:0]        rd_buf;
  logic [2:0]        tx_bit;
  logic              tx_live;
  logic [1:0]        id_idx;
  logic [7:0]        id_byte, src_byte;
  logic [7:0]        rx_byte;
  logic              byte_done, tx_fall, tx_load;
  sfe_cmd_e          dec;

  assign rx_byte   = {rx_sr[6:0], si_s};
  assign byte_done = rise && (bit_idx == 3'd7);
  assign tx_fall   = fall && (st == ST_TX);
  assign tx_load   = tx_fall && (tx_bit == 3'd0);

  always_comb begin
    dec = sfe_decode(rx_byte);
    if (wr_busy && dec != C_RDSR) dec = C_BAD;
  end

  always_comb begin
    case (id_idx)
      2'd0:    id_byte = ID_MFR;
      2'd1:    id_byte = ID_TYPE;
      default: id_byte = ID_CAP;
    endcase
    case (cmd)
      C_RDSR:  src_byte = status_in;
      C_ID:    src_byte = id_byte;
      default: src_byte = rd_buf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OP;  cmd <= C_BAD;  rx_sr <= '0;  bit_idx <= '0;  abyte <= '0;
      addr <= '0;  wr_data <= '0;  prog_any <= 1'b0;  fetch_q <= 1'b0;
      fetch_d <= 1'b0;  rd_buf <= '0;  tx_bit <= '0;  tx_live <= 1'b0;  id_idx <= '0;
      prog_valid <= 1'b0;  prog_addr <= '0;  prog_data <= '0;
      cmd_valid <= 1'b0;  cmd_op <= '0;  cmd_addr <= '0;  cmd_data <= '0;
    end else begin
      fetch_q    <= 1'b0;
      fetch_d    <= fetch_q;
      cmd_valid  <= 1'b0;
      prog_valid <= 1'b0;
      if (fetch_d) rd_buf <= arr_rd_data;

      if (desel) begin
        if (st == ST_ARMED ||
            (st == ST_DATA && cmd == C_PROG && prog_any && bit_idx == 3'd0)) begin
          cmd_valid <= 1'b1;
          cmd_op    <= sfe_op_of(cmd);
          cmd_addr  <= (cmd == C_PROG) ? {addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}} : addr;
          cmd_data  <= wr_data;
        end
      end

      if (!sel) begin
        st <= ST_OP;  bit_idx <= '0;  abyte <= '0;  tx_bit <= '0;
        tx_live <= 1'b0;  id_idx <= '0;  prog_any <= 1'b0;
      end else begin
        if (rise) begin
          rx_sr   <= rx_byte;
          bit_idx <= bit_idx + 3'd1;
          case (st)
            ST_ARMED: st <= ST_DEAD;   // stray bit cancels the strobe
            ST_OP: if (byte_done) begin
              cmd   <= dec;
              abyte <= '0;
              case (dec)
                C_WREN, C_WRDI, C_CHIP:                  st <= ST_ARMED;
                C_RDSR, C_ID:                            st <= ST_TX;
                C_WRSR:                                  st <= ST_DATA;
                C_READ, C_FAST, C_PROG, C_SECT, C_BLOCK: st <= ST_ADDR;
                default:                                 st <= ST_DEAD;
              endcase
            end
            ST_ADDR: if (byte_done) begin
              addr  <= {addr[ADDR_W-9:0], rx_byte};
              abyte <= abyte + 1'b1;
              if (abyte == ABYTE_W'(ADDR_BYTES-1)) begin
                case (cmd)
                  C_READ:  begin fetch_q <= 1'b1; st <= ST_TX;    end
                  C_FAST:  begin fetch_q <= 1'b1; st <= ST_DUMMY; end
                  C_PROG:  st <= ST_DATA;
                  default: st <= ST_ARMED;
                endcase
              end
            end
            ST_DUMMY: if (byte_done) st <= ST_TX;
            ST_DATA: if (byte_done) begin
              if (cmd == C_WRSR) begin
                wr_data <= rx_byte;
                st      <= ST_ARMED;
              end else begin
                prog_valid <= 1'b1;
                prog_addr  <= addr;
                prog_data  <= rx_byte;
                prog_any   <= 1'b1;
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
              end
            end
            default: ;
          endcase
        end

        if (tx_fall) begin
          tx_bit <= tx_bit + 3'd1;
          if (tx_load) begin
            tx_live <= 1'b1;
            if (cmd == C_ID)
              id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
            else if (cmd != C_RDSR) begin
              addr    <= addr + 1'b1;   // wraps across the whole array
              fetch_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  sfe_tx #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(!sel), .load(tx_load),
    .shift(tx_fall && !tx_load), .din(src_byte), .so(spi_so)
  );

  assign spi_so_oe   = sel && (st == ST_TX) && tx_live && !paused;
  assign arr_rd_en   = fetch_q;
  assign arr_rd_addr = addr;
endmodule

// File: rtl/sfe_cmd_frontend_chk.sv
module sfe_cmd_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic paused,
  input logic fall,
  input logic so,
  input logic so_oe,
  input logic cmd_valid,
  input logic prog_valid
);
  assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> sel);

  assert_so_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !$past(fall)) |-> $stable(so));

  assert_paused_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_strobe_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !sel);

  assert_prog_beat_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |=> !prog_valid);
endmodule

bind sfe_cmd_frontend sfe_cmd_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .paused(paused), .fall(fall),
  .so(spi_so), .so_oe(spi_so_oe), .cmd_valid(cmd_valid), .prog_valid(prog_valid)
);

// File: tb/tb_sfe_cmd_frontend.sv
module tb_sfe_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_hold_n = 1'b1, spi_si = 1'b0;
  logic        spi_so, spi_so_oe;
  logic        wr_busy = 1'b0;
  logic [7:0]  status_in = 8'hA5;
  logic        arr_rd_en;
  logic [18:0] arr_rd_addr;
  logic [7:0]  arr_rd_data = 8'h00;
  logic        prog_valid;
  logic [18:0] prog_addr;
  logic [7:0]  prog_data;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data;

  int n_cmp = 0, n_bad = 0, cs_hi_cnt = 0;
  bit cpol = 1'b0, oe_seen = 1'b0, rd_seen = 1'b0;
  int q_op[$], q_addr[$], q_dat[$], q_pa[$], q_pd[$];

  always #4 clk = ~clk;

  sfe_cmd_frontend dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_hold_n(spi_hold_n), .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .wr_busy(wr_busy), .status_in(status_in), .arr_rd_en(arr_rd_en),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .prog_valid(prog_valid),
    .prog_addr(prog_addr), .prog_data(prog_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  function automatic logic [7:0] memf(input logic [18:0] a);
    logic [31:0] t;
    t = {13'd0, a} * 32'd7 + {21'd0, a[18:8]} + {29'd0, a[18:16]} * 32'd13;
    return t[7:0];
  endfunction

  always_ff @(posedge clk) if (arr_rd_en) arr_rd_data <= memf(arr_rd_addr);

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison of strobes, beats and deselected output enable
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_so_oe) oe_seen = 1'b1;
      if (arr_rd_en) rd_seen = 1'b1;
      if (cmd_valid) begin
        n_cmp++;
        if (q_op.size() == 0) begin
          n_bad++;
          $display("FAIL R11: actual unexpected strobe op %0d expected none", cmd_op);
        end else begin
          int eo, ea, ed;
          eo = q_op.pop_front(); ea = q_addr.pop_front(); ed = q_dat.pop_front();
          if (int'(cmd_op) != eo || (ea >= 0 && int'(cmd_addr) != ea) ||
              (ed >= 0 && int'(cmd_data) != ed)) begin
            n_bad++;
            $display("FAIL R11: actual op %0d addr %0h data %0h expected op %0d addr %0h data %0h",
                     cmd_op, cmd_addr, cmd_data, eo, ea, ed);
          end
        end
      end
      if (prog_valid) begin
        n_cmp++;
        if (q_pa.size() == 0) begin
          n_bad++;
          $display("FAIL R12: actual unexpected beat %0h expected none", prog_addr);
        end else begin
          int pa, pd;
          pa = q_pa.pop_front(); pd = q_pd.pop_front();
          if (int'(prog_addr) != pa || int'(prog_data) != pd) begin
            n_bad++;
            $display("FAIL R12: actual beat %0h/%0h expected %0h/%0h",
                     prog_addr, prog_data, pa, pd);
          end
        end
      end
      if (cs_hi_cnt >= 4) begin
        n_cmp++;
        if (spi_so_oe) begin
          n_bad++;
          $display("FAIL R1: actual so_oe 1 while deselected expected 0");
        end
      end
      cs_hi_cnt = spi_cs_n ? cs_hi_cnt + 1 : 0;
    end
  end

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input bit m);
    cpol = m; spi_sck = m;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_low();
    spi_cs_n = 1'b0; half();
  endtask

  task automatic cs_high();
    if (!cpol && spi_sck) begin spi_sck = 1'b0; half(); end
    else half();
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r, output logic oe);
    if (spi_sck) spi_sck = 1'b0;
    spi_si = b; half();
    spi_sck = 1'b1; half();
    r = spi_so; oe = spi_so_oe;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
    logic r, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r, oe);
      rx[i] = r;
      if (!oe) oe_all = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d; bit o;
    xbyte(b, d, o);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic expect_byte(input string req, input logic [7:0] exp);
    logic [7:0] d; bit o;
    xbyte(8'h00, d, o);
    chk(req, d, exp);
    chk({req, " drive"}, o, 1);
  endtask

  task automatic want_cmd(input int op, input int a, input int d);
    q_op.push_back(op); q_addr.push_back(a); q_dat.push_back(d);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic r, oe;
    bit o;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 so_oe after reset", spi_so_oe, 0);
    chk("R1 cmd_valid after reset", cmd_valid, 0);
    chk("R1 arr_rd_en after reset", arr_rd_en, 0);

    // R3 R2 status read in mode 0, repeated
    cs_low(); send(8'h05);
    expect_byte("R3 status 1", 8'hA5);
    expect_byte("R3 status 2", 8'hA5);
    status_in = 8'h3C;
    expect_byte("R3 status live", 8'h3C);
    cs_high();

    // R2 status read in mode 3
    set_mode(1'b1);
    cs_low(); send(8'h05); expect_byte("R2 mode3 status", 8'h3C); cs_high();
    set_mode(1'b0);

    // R4 read, top address bits ignored
    oe_seen = 1'b0;
    cs_low(); send(8'h03); send_addr(24'hFD1234);
    chk("R4 no drive during address", oe_seen, 0);
    for (int i = 0; i < 4; i++) expect_byte("R4 read data", memf(19'h51234 + 19'(i)));
    cs_high();

    // R5 wrap, in mode 3
    set_mode(1'b1);
    cs_low(); send(8'h03); send_addr(24'h07FFFE);
    expect_byte("R5 7FFFE", memf(19'h7FFFE));
    expect_byte("R5 7FFFF", memf(19'h7FFFF));
    expect_byte("R5 00000", memf(19'h00000));
    expect_byte("R5 00001", memf(19'h00001));
    cs_high();
    set_mode(1'b0);

    // R6 fast read with dummy byte
    cs_low(); send(8'h0B); send_addr(24'h000100);
    oe_seen = 1'b0; send(8'hFF);
    chk("R6 dummy byte undriven", oe_seen, 0);
    for (int i = 0; i < 3; i++) expect_byte("R6 fast data", memf(19'h00100 + 19'(i)));
    cs_high();

    // R7 identification, both opcodes
    cs_low(); send(8'h9F);
    for (int i = 0; i < 7; i++)
      expect_byte("R7 id 9F", (i % 3 == 0) ? 8'h1F : (i % 3 == 1) ? 8'h66 : 8'h04);
    cs_high();
    set_mode(1'b1);
    cs_low(); send(8'hAB);
    expect_byte("R7 id AB 0", 8'h1F); expect_byte("R7 id AB 1", 8'h66);
    expect_byte("R7 id AB 2", 8'h04);
    cs_high();
    set_mode(1'b0);

    // R8 unknown opcode locks out the rest of the selection
    oe_seen = 1'b0;
    cs_low(); send(8'hFF); send(8'h06); send(8'h05); send(8'h03); cs_high();
    chk("R8 no drive after unknown opcode", oe_seen, 0);
    cs_low(); send(8'h05); expect_byte("R8 next selection works", 8'h3C); cs_high();

    // R11 strobes
    want_cmd(1, -1, -1); cs_low(); send(8'h06); cs_high();
    want_cmd(2, -1, -1); cs_low(); send(8'h04); cs_high();
    want_cmd(7, -1, -1); cs_low(); send(8'h60); cs_high();
    set_mode(1'b1);
    want_cmd(7, -1, -1); cs_low(); send(8'hC7); cs_high();
    set_mode(1'b0);
    want_cmd(3, -1, 8'h9C); cs_low(); send(8'h01); send(8'h9C); cs_high();
    want_cmd(5, 19'h12345, -1); cs_low(); send(8'hD7); send_addr(24'h012345); cs_high();
    want_cmd(5, 19'h00FFF, -1); cs_low(); send(8'h20); send_addr(24'hF00FFF); cs_high();
    want_cmd(6, 19'h20000, -1); cs_low(); send(8'h52); send_addr(24'h0A0000); cs_high();
    want_cmd(6, 19'h7ABCD, -1); cs_low(); send(8'hD8); send_addr(24'h07ABCD); cs_high();
    // R11 stray bits cancel the strobe
    cs_low(); send(8'h06); xbit(1'b0, r, oe); xbit(1'b1, r, oe); cs_high();
    cs_low(); send(8'h01); cs_high();
    repeat (4) @(negedge clk);
    chk("R11 strobes all seen", q_op.size(), 0);

    // R12 program with page wrap
    q_pa.push_back(19'h003FE); q_pd.push_back(8'h11);
    q_pa.push_back(19'h003FF); q_pd.push_back(8'h22);
    q_pa.push_back(19'h00300); q_pd.push_back(8'h33);
    want_cmd(4, 19'h00300, -1);
    cs_low(); send(8'h02); send_addr(24'h0003FE);
    send(8'h11); send(8'h22); send(8'h33); cs_high();
    // R12 partial trailing byte: beat issued, no commit
    q_pa.push_back(19'h40010); q_pd.push_back(8'h5A);
    cs_low(); send(8'h02); send_addr(24'h040010); send(8'h5A);
    for (int i = 0; i < 4; i++) xbit(1'b1, r, oe);
    cs_high();
    // R12 no data byte: no commit
    cs_low(); send(8'h02); send_addr(24'h040010); cs_high();
    repeat (4) @(negedge clk);
    chk("R12 beats all seen", q_pa.size(), 0);

    // R9 busy lockout
    wr_busy = 1'b1;
    oe_seen = 1'b0; rd_seen = 1'b0;
    cs_low(); send(8'h03); send_addr(24'h000010); send(8'h00); send(8'h00); cs_high();
    chk("R9 busy read undriven", oe_seen, 0);
    chk("R9 busy read no fetch", rd_seen, 0);
    cs_low(); send(8'h06); cs_high();
    cs_low(); send(8'h60); cs_high();
    cs_low(); send(8'h05); expect_byte("R9 status while busy", 8'h3C); cs_high();
    wr_busy = 1'b0;

    // R10 pause in the middle of an output byte
    cs_low(); send(8'h03); send_addr(24'h000200);
    expect_byte("R10 byte before pause", memf(19'h00200));
    for (int i = 7; i >= 5; i--) begin
      xbit(1'b0, r, oe);
      d[i] = r;
    end
    spi_sck = 1'b0; half();
    spi_hold_n = 1'b0; half();
    oe_seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      spi_si = k[0]; spi_sck = 1'b1; half(); spi_sck = 1'b0; half();
    end
    chk("R10 undriven while paused", oe_seen, 0);
    spi_hold_n = 1'b1; half();
    for (int i = 4; i >= 0; i--) begin
      xbit(1'b1, r, oe);
      d[i] = r;
    end
    chk("R10 byte across pause", d, memf(19'h00201));
    chk("R10 drive after resume", oe, 1);
    xbyte(8'h00, d, o);
    chk("R10 byte after pause", d, memf(19'h00202));
    cs_high();

    repeat (20) @(negedge clk);
    chk("R11 no pending strobes", q_op.size(), 0);
    chk("R12 no pending beats", q_pa.size(), 0);
    finish_run();
  end
endmodule